// File: doc/BRIEF.md
# Peripheral DMA channel controller

This block moves data words between a set of serial peripherals and system memory so that the processor does not have to copy each word itself. Every channel has a transmit direction (memory to peripheral) and a receive direction (peripheral to memory). Each direction keeps two pointer/counter sets. The current set drives the transfer in progress. The next set holds a second buffer that software queues in advance. When the current counter runs out, the controller promotes the next set on its own. Software can then reload buffers without reacting within the same cycle that a buffer ends.

Peripherals ask for service by holding a transmit or receive request line until they see the matching acknowledge pulse. A fixed-priority arbiter picks one eligible request per transfer slot. A transmit slot reads one memory word in a single cycle and hands it to the peripheral. A receive slot takes the peripheral's word in one cycle and writes it to memory in the following cycle. No new grant is made during that write cycle. Per-direction flags report when the current buffer has ended and when both buffers are used up. Software programs the controller through a simple one-cycle write port.

Top module: `pdma_engine`

## Requirements
- R1: A write with `cfg_we` high updates the addressed direction (`cfg_chan`, `cfg_dir` 0 = transmit, 1 = receive), with field code `cfg_sel`: 0 current pointer, 1 current counter, 2 next pointer, 3 next counter, 4 control, 5 transfer size. Writing a nonzero current counter arms the direction.
- R2: A granted transmit request completes in one cycle. In that cycle `mem_req` is 1, `mem_we` is 0, `mem_addr` equals the current pointer, the channel's `tx_ack` bit pulses, and `tx_data` carries `mem_rdata`.
- R3: A granted receive request takes two cycles. In the first, the channel's `rx_ack` bit pulses and `per_rdata` of that channel is captured. In the next cycle `mem_req` and `mem_we` are 1, with the captured pointer and word on `mem_addr` and `mem_wdata`. No acknowledge is issued in that second cycle.
- R4: After each word, the pointer advances by the transfer size (size code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) and the current counter drops by one.
- R5: Among simultaneous eligible requests, receive outranks transmit. Within one direction, the higher channel number wins.
- R6: A direction whose current counter is zero ignores its request line. It issues no acknowledge and performs no memory access.
- R7: Control write bit 0 enables servicing and bit 1 disables it; disable wins if both bits are set. A disabled direction ignores its request line.
- R8: When the current counter is zero and the next counter is nonzero, the next pointer and next counter are copied into the current set, and the next counter is cleared, all in the next cycle.
- R9: `tx_end`/`rx_end` is 1 exactly when the current counter is zero. `tx_drained`/`rx_drained` is 1 exactly when both the current and the next counters are zero.
- R10: At most one acknowledge is issued per cycle across all channels and directions.
- R11: After reset all counters are zero, all directions are disabled, the size is 4 bytes, every end and drained flag is 1, and `mem_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_chan | input | $clog2(NUM_CH) | Channel addressed by the write |
| cfg_dir | input | 1 | 0 transmit, 1 receive |
| cfg_sel | input | 3 | Field code of the write |
| cfg_wdata | input | 32 | Write data |
| tx_req | input | NUM_CH | Transmit request per channel |
| rx_req | input | NUM_CH | Receive request per channel |
| per_rdata | input | NUM_CH*32 | Received word offered by each peripheral |
| tx_ack | output | NUM_CH | One-cycle transmit acknowledge |
| rx_ack | output | NUM_CH | One-cycle receive acknowledge |
| tx_data | output | 32 | Word handed to the acknowledged transmitter |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle |
| tx_end | output | NUM_CH | Transmit current counter is zero |
| tx_drained | output | NUM_CH | Transmit current and next counters are zero |
| rx_end | output | NUM_CH | Receive current counter is zero |
| rx_drained | output | NUM_CH | Receive current and next counters are zero |

## Verification
The bench raises four requests in the same cycle and expects the order receive 2, receive 0, transmit 2, transmit 0. A reversed or direction-blind arbiter would put a transmit first or swap the channel order. It queues a next buffer behind a current one, and separately loads only a next buffer. A missed promotion would stall the stream, and a promotion without clearing the next counter would replay that buffer a second time. It holds requests against a disabled direction and against a zero counter. A design that ignored either gate would produce an unexpected acknowledge. Byte, half-word and word sizes each appear in an address sequence, so a wrong stride shows up as a wrong address. Every receive acknowledge must be followed by its write in the next cycle, which catches a one-cycle receive path or a grant that slips into the write cycle.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    // register field selected by a configuration write
    typedef enum logic [2:0] {
        FLD_CUR_PTR = 3'd0,
        FLD_CUR_CNT = 3'd1,
        FLD_NXT_PTR = 3'd2,
        FLD_NXT_CNT = 3'd3,
        FLD_CTRL    = 3'd4,
        FLD_SIZE    = 3'd5
    } field_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_WRITE = 1'b1
    } seq_state_e;

    // pending receive word waiting for its memory write
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rx_hold_t;

    localparam int CTRL_ON_BIT  = 0;
    localparam int CTRL_OFF_BIT = 1;

    function automatic logic [ADDR_W-1:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_bytes = ADDR_W'(1);
            2'd1:    size_bytes = ADDR_W'(2);
            default: size_bytes = ADDR_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/pdma_dir_unit.sv
module pdma_dir_unit
    import pdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  field_e            wr_field,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              eligible,
    output logic              end_flag,
    output logic              drained_flag
);

    logic [CNT_W-1:0]  cur_cnt;
    logic [ADDR_W-1:0] nxt_ptr;
    logic [CNT_W-1:0]  nxt_cnt;
    logic              enabled;
    logic [1:0]        size_code;
    logic [ADDR_W-1:0] stride;

    assign stride = size_bytes(size_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ptr   <= '0;
            cur_cnt   <= '0;
            nxt_ptr   <= '0;
            nxt_cnt   <= '0;
            enabled   <= 1'b0;
            size_code <= 2'd2;
        end else begin
            if (step) begin
                cur_ptr <= cur_ptr + stride;
                cur_cnt <= cur_cnt - CNT_W'(1);
            end else if (cur_cnt == '0 && nxt_cnt != '0) begin
                cur_ptr <= nxt_ptr;
                cur_cnt <= nxt_cnt;
                nxt_cnt <= '0;
            end
            if (wr_en) begin
                case (wr_field)
                    FLD_CUR_PTR: cur_ptr <= wr_data;
                    FLD_CUR_CNT: cur_cnt <= wr_data[CNT_W-1:0];
                    FLD_NXT_PTR: nxt_ptr <= wr_data;
                    FLD_NXT_CNT: nxt_cnt <= wr_data[CNT_W-1:0];
                    FLD_CTRL: begin
                        if (wr_data[CTRL_OFF_BIT])
                            enabled <= 1'b0;
                        else if (wr_data[CTRL_ON_BIT])
                            enabled <= 1'b1;
                    end
                    FLD_SIZE: size_code <= wr_data[1:0];
                    default: ;
                endcase
            end
        end
    end

    assign eligible     = enabled && (cur_cnt != '0);
    assign end_flag     = (cur_cnt == '0);
    assign drained_flag = (cur_cnt == '0) && (nxt_cnt == '0);

    AST_NO_STEP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        step |-> cur_cnt != '0); // R6

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en) |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1))
                          && (cur_ptr == $past(cur_ptr) + $past(stride))); // R4

    AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
        (cur_cnt == '0 && nxt_cnt != '0 && !wr_en)
            |=> (cur_cnt == $past(nxt_cnt)) && (cur_ptr == $past(nxt_ptr))
                && (nxt_cnt == '0)); // R8

endmodule

// File: rtl/pdma_arbiter.sv
module pdma_arbiter #(
    parameter int REQS = 6,
    localparam int IW = (REQS > 1) ? $clog2(REQS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [REQS-1:0] req,
    output logic            gnt_valid,
    output logic [IW-1:0]   gnt_idx
);

    logic [REQS-1:0] gnt_vec;

    // highest index wins: receive slots sit above transmit slots
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        gnt_vec   = '0;
        for (int k = 0; k < REQS; k++) begin
            if (req[k]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(k);
                gnt_vec   = '0;
                gnt_vec[k] = 1'b1;
            end
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_vec)); // R10

    AST_GRANT_IS_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> ((gnt_vec & req) == gnt_vec) && (gnt_vec != '0)); // R5

endmodule

// File: rtl/pdma_sequencer.sv
module pdma_sequencer
    import pdma_pkg::*;
#(
    parameter int NUM_CH = 3,
    localparam int REQS = 2 * NUM_CH,
    localparam int IW = $clog2(REQS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gnt_valid,
    input  logic [IW-1:0]     gnt_idx,
    input  logic [ADDR_W-1:0] sel_ptr,
    input  logic [DATA_W-1:0] sel_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [REQS-1:0]   step_vec,
    output logic [REQS-1:0]   ack_vec
);

    seq_state_e state, state_nx;
    rx_hold_t   hold;
    logic [IW-1:0] hold_idx;
    logic       take_rx;

    assign take_rx = (state == SEQ_IDLE) && gnt_valid && (int'(gnt_idx) >= NUM_CH);

    always_comb begin
        state_nx  = state;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        step_vec  = '0;
        ack_vec   = '0;
        if (state == SEQ_IDLE) begin
            if (gnt_valid) begin
                for (int k = 0; k < REQS; k++)
                    ack_vec[k] = (k == int'(gnt_idx));
                if (int'(gnt_idx) < NUM_CH) begin
                    mem_req  = 1'b1;
                    mem_addr = sel_ptr;
                    step_vec = ack_vec;
                end else begin
                    state_nx = SEQ_WRITE;
                end
            end
        end else begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = hold.addr;
            mem_wdata = hold.data;
            for (int k = 0; k < REQS; k++)
                step_vec[k] = (k == int'(hold_idx));
            state_nx  = SEQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            hold     <= '0;
            hold_idx <= '0;
        end else begin
            state <= state_nx;
            if (take_rx) begin
                hold.addr <= sel_ptr;
                hold.data <= sel_rdata;
                hold_idx  <= gnt_idx;
            end
        end
    end

    AST_RX_WRITE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (|ack_vec[REQS-1:NUM_CH]) |=> mem_req && mem_we
                                      && (step_vec == $past(ack_vec))
                                      && (ack_vec == '0)); // R3

    AST_TX_READ: assert property (@(posedge clk) disable iff (rst)
        (|ack_vec[NUM_CH-1:0]) |-> mem_req && !mem_we && (mem_addr == sel_ptr)); // R2

endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    localparam int CHW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int REQS = 2 * NUM_CH,
    localparam int IW   = $clog2(REQS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [CHW-1:0]           cfg_chan,
    input  logic                     cfg_dir,
    input  logic [2:0]               cfg_sel,
    input  logic [DATA_W-1:0]        cfg_wdata,
    input  logic [NUM_CH-1:0]        tx_req,
    input  logic [NUM_CH-1:0]        rx_req,
    input  logic [NUM_CH*DATA_W-1:0] per_rdata,
    output logic [NUM_CH-1:0]        tx_ack,
    output logic [NUM_CH-1:0]        rx_ack,
    output logic [DATA_W-1:0]        tx_data,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic [NUM_CH-1:0]        tx_end,
    output logic [NUM_CH-1:0]        tx_drained,
    output logic [NUM_CH-1:0]        rx_end,
    output logic [NUM_CH-1:0]        rx_drained
);

    logic [ADDR_W-1:0] ptr_all [REQS];
    logic [REQS-1:0]   elig_all;
    logic [REQS-1:0]   req_all;
    logic [REQS-1:0]   step_vec;
    logic [REQS-1:0]   ack_vec;
    logic              gnt_valid;
    logic [IW-1:0]     gnt_idx;
    logic [ADDR_W-1:0] sel_ptr;
    logic [DATA_W-1:0] sel_rdata;
    field_e            wr_field;

    assign wr_field = field_e'(cfg_sel);

    // slot k < NUM_CH is transmit of channel k, slot NUM_CH+k is receive of channel k
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pdma_dir_unit #(.CNT_W(CNT_W)) u_tx (
            .clk          (clk),
            .rst          (rst),
            .wr_en        (cfg_we && !cfg_dir && (cfg_chan == CHW'(g))),
            .wr_field     (wr_field),
            .wr_data      (cfg_wdata),
            .step         (step_vec[g]),
            .cur_ptr      (ptr_all[g]),
            .eligible     (elig_all[g]),
            .end_flag     (tx_end[g]),
            .drained_flag (tx_drained[g])
        );
        pdma_dir_unit #(.CNT_W(CNT_W)) u_rx (
            .clk          (clk),
            .rst          (rst),
            .wr_en        (cfg_we && cfg_dir && (cfg_chan == CHW'(g))),
            .wr_field     (wr_field),
            .wr_data      (cfg_wdata),
            .step         (step_vec[NUM_CH+g]),
            .cur_ptr      (ptr_all[NUM_CH+g]),
            .eligible     (elig_all[NUM_CH+g]),
            .end_flag     (rx_end[g]),
            .drained_flag (rx_drained[g])
        );
    end

    assign req_all = {rx_req, tx_req} & elig_all;

    pdma_arbiter #(.REQS(REQS)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req_all),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    always_comb begin
        sel_ptr   = '0;
        sel_rdata = '0;
        for (int k = 0; k < REQS; k++)
            if (k == int'(gnt_idx)) sel_ptr = ptr_all[k];
        for (int c = 0; c < NUM_CH; c++)
            if (NUM_CH + c == int'(gnt_idx)) sel_rdata = per_rdata[c*DATA_W +: DATA_W];
    end

    pdma_sequencer #(.NUM_CH(NUM_CH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .sel_ptr   (sel_ptr),
        .sel_rdata (sel_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .step_vec  (step_vec),
        .ack_vec   (ack_vec)
    );

    assign tx_ack  = ack_vec[NUM_CH-1:0];
    assign rx_ack  = ack_vec[REQS-1:NUM_CH];
    assign tx_data = mem_rdata;

    AST_ACK_ONLY_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        ((tx_ack & ~tx_req) == '0) && ((rx_ack & ~rx_req) == '0)); // R7

endmodule

// File: tb/pdma_engine_test.sv
module pdma_engine_test;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_chan = '0;
    logic            cfg_dir = 1'b0;
    logic [2:0]      cfg_sel = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [N-1:0]    tx_req, rx_req, tx_ack, rx_ack;
    logic [N*32-1:0] per_rdata;
    logic [31:0]     tx_data, mem_addr, mem_wdata, mem_rdata;
    logic            mem_req, mem_we;
    logic [N-1:0]    tx_end, tx_drained, rx_end, rx_drained;

    pdma_engine #(.NUM_CH(N), .CNT_W(16)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_dir(cfg_dir),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .tx_req(tx_req), .rx_req(rx_req),
        .per_rdata(per_rdata), .tx_ack(tx_ack), .rx_ack(rx_ack), .tx_data(tx_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tx_end(tx_end), .tx_drained(tx_drained),
        .rx_end(rx_end), .rx_drained(rx_drained)
    );

    // memory model: read data is a function of the address
    assign mem_rdata = {16'hA5A5, mem_addr[15:0]};

    // peripheral model: request held while asked != done
    int tx_asked [N];
    int rx_asked [N];
    int tx_done  [N];
    int rx_done  [N];

    initial for (int i = 0; i < N; i++) begin
        tx_asked[i] = 0; rx_asked[i] = 0; tx_done[i] = 0; rx_done[i] = 0;
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            tx_req[i] = (tx_asked[i] != tx_done[i]);
            rx_req[i] = (rx_asked[i] != rx_done[i]);
            per_rdata[i*32 +: 32] = {8'hC0, 8'(i), 16'(rx_done[i])};
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (tx_ack[i]) tx_done[i] <= tx_done[i] + 1;
            if (rx_ack[i]) rx_done[i] <= rx_done[i] + 1;
        end
    end

    typedef struct packed {
        logic        wr;
        logic [7:0]  ch;
        logic [31:0] addr;
        logic [31:0] data;
    } item_t;

    item_t exp_q[$];
    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_tx(input int ch, input logic [31:0] addr);
        item_t it;
        it.wr = 1'b0; it.ch = 8'(ch); it.addr = addr; it.data = {16'hA5A5, addr[15:0]};
        exp_q.push_back(it);
    endtask

    task automatic push_rx(input int ch, input int k, input logic [31:0] addr);
        item_t it;
        it.wr = 1'b1; it.ch = 8'(ch); it.addr = addr; it.data = {8'hC0, 8'(ch), 16'(k)};
        exp_q.push_back(it);
    endtask

    // monitor: compares bus activity with the scoreboard queue
    bit rx_pending = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_pending)
                check(mem_req && mem_we && tx_ack == '0 && rx_ack == '0,
                      "R3 write follows rx ack", {62'd0, mem_req, mem_we}, 64'd3);
            rx_pending = (rx_ack != '0);
            if ((tx_ack != '0) || (mem_req && mem_we)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6/R7 unexpected transfer", {32'd0, mem_addr}, 64'd0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    if (!e.wr) begin
                        check(tx_ack == N'(1 << e.ch) && mem_req && !mem_we,
                              "R2/R5 tx grant", {61'd0, tx_ack}, 64'(1 << e.ch));
                        check(mem_addr == e.addr, "R2/R4 tx addr",
                              {32'd0, mem_addr}, {32'd0, e.addr});
                        check(tx_data == e.data, "R2 tx data",
                              {32'd0, tx_data}, {32'd0, e.data});
                    end else begin
                        check(mem_addr == e.addr, "R3/R4 rx addr",
                              {32'd0, mem_addr}, {32'd0, e.addr});
                        check(mem_wdata == e.data, "R3/R5 rx data",
                              {32'd0, mem_wdata}, {32'd0, e.data});
                    end
                end
            end
        end
    end

    task automatic cfg(input int ch, input bit dir, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_dir = dir; cfg_sel = 3'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic arm(input int ch, input bit dir, input logic [31:0] p, input int n,
                       input int sz);
        cfg(ch, dir, 5, 32'(sz));
        cfg(ch, dir, 0, p);
        cfg(ch, dir, 1, 32'(n));
    endtask

    task automatic drain();
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2/R3 all expected transfers seen",
              64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(tx_end == '1 && rx_end == '1, "R11 end flags after reset",
              {58'd0, tx_end, rx_end}, 64'h3f);
        check(tx_drained == '1 && rx_drained == '1, "R11 drained flags after reset",
              {58'd0, tx_drained, rx_drained}, 64'h3f);
        check(!mem_req, "R11 bus idle after reset", {63'd0, mem_req}, 64'd0);

        for (int c = 0; c < N; c++) begin
            cfg(c, 1'b0, 4, 32'h1);
            cfg(c, 1'b1, 4, 32'h1);
        end
        // R6: enabled but counter zero (also the reset state of R11)
        tx_asked[0] = 1;
        repeat (8) @(negedge clk);
        check(tx_done[0] == 0, "R6/R11 zero counter ignores request", 64'(tx_done[0]), 64'd0);
        tx_asked[0] = tx_done[0];

        // R1/R2/R4 transmit word stream
        arm(0, 1'b0, 32'h100, 3, 2);
        check(tx_end[0] == 1'b0 && tx_drained[0] == 1'b0, "R1/R9 armed flags",
              {62'd0, tx_end[0], tx_drained[0]}, 64'd0);
        push_tx(0, 32'h100); push_tx(0, 32'h104); push_tx(0, 32'h108);
        tx_asked[0] += 3;
        drain();
        check(tx_end[0] && tx_drained[0], "R9 flags after tx buffer", {62'd0, tx_end[0],
              tx_drained[0]}, 64'd3);

        // R3/R4 receive half-word stream
        arm(1, 1'b1, 32'h200, 2, 1);
        push_rx(1, 0, 32'h200); push_rx(1, 1, 32'h202);
        rx_asked[1] += 2;
        drain();
        check(rx_end[1], "R9 rx end after buffer", {63'd0, rx_end[1]}, 64'd1);

        // R5/R10 priority: four requests in one cycle
        arm(0, 1'b0, 32'h600, 1, 2);
        arm(2, 1'b0, 32'h610, 1, 2);
        arm(0, 1'b1, 32'h620, 1, 2);
        arm(2, 1'b1, 32'h630, 1, 2);
        push_rx(2, 0, 32'h630); push_rx(0, 0, 32'h620);
        push_tx(2, 32'h610);    push_tx(0, 32'h600);
        @(negedge clk);
        tx_asked[0] += 1; tx_asked[2] += 1; rx_asked[0] += 1; rx_asked[2] += 1;
        drain();

        // R8 hand-over with byte size, current then next
        arm(1, 1'b0, 32'h300, 2, 0);
        cfg(1, 1'b0, 2, 32'h380);
        cfg(1, 1'b0, 3, 32'd2);
        check(!tx_drained[1], "R9 drained low with next queued", {63'd0, tx_drained[1]}, 64'd0);
        push_tx(1, 32'h300); push_tx(1, 32'h301); push_tx(1, 32'h380); push_tx(1, 32'h381);
        tx_asked[1] += 4;
        drain();
        check(tx_end[1] && tx_drained[1], "R8/R9 both buffers used",
              {62'd0, tx_end[1], tx_drained[1]}, 64'd3);

        // R8 next only, with an idle current set
        cfg(2, 1'b0, 2, 32'h400);
        cfg(2, 1'b0, 3, 32'd1);
        @(negedge clk);
        check(!tx_end[2], "R8 next promoted into current", {63'd0, tx_end[2]}, 64'd0);
        push_tx(2, 32'h400);
        tx_asked[2] += 1;
        drain();

        // R7 disable gates requests, disable wins over enable
        arm(0, 1'b0, 32'h500, 1, 2);
        cfg(0, 1'b0, 4, 32'h3);
        tx_asked[0] += 1;
        repeat (10) @(negedge clk);
        check(tx_asked[0] - tx_done[0] == 1, "R7 disabled ignores request",
              64'(tx_done[0]), 64'(tx_asked[0] - 1));
        check(!tx_end[0], "R7 counter kept while disabled", {63'd0, tx_end[0]}, 64'd0);
        push_tx(0, 32'h500);
        cfg(0, 1'b0, 4, 32'h1);
        drain();

        // R6 receive with zero counter
        rx_asked[1] += 1;
        repeat (10) @(negedge clk);
        check(rx_asked[1] - rx_done[1] == 1, "R6 rx zero counter ignored",
              64'(rx_done[1]), 64'(rx_asked[1] - 1));
        rx_asked[1] = rx_done[1];
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule